// File: doc/BRIEF.md
# Serial Frame Transmitter with Idle and Break Queuing

The block serialises asynchronous frames onto one output line. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then one or two high stop bits. An external divider supplies a one-cycle `bit_tick` strobe at the bit rate, so the line moves exactly one bit per tick. A one-entry buffer takes a data word on a write strobe and hands it to the shifter when the shifter is free. Two other kinds of item can be queued next to data: an idle character and a break character. An idle character is a frame-length run of high bits. A break character is a run of low bits.

Software queues an idle character by taking the transmit enable low and then high again while a frame is on the line. It queues a break by pulsing the break request. Holding the break request high sends breaks back to back. When the enable goes low, the block keeps the line until the item already shifting has finished. Only then does it give up pin ownership. A direction input lets the output driver be turned off for a shared single-wire line.

Top module: `sertx_core`

## Requirements
- R1: After reset `buf_empty`=1, `tx_done`=1 and `txd`=1. While `tx_en`=0 and nothing is shifting, `pin_owned`=0.
- R2: Let F = 10 + `nine_bit` + `extra_stop`. When an item starts on a `bit_tick`, the line shows bit 0 of that item after that tick and moves one bit per later tick. A data frame is bit 0 = 0, bits 1..8 (or 1..9 when `nine_bit`=1) = data LSB first, and the remaining bits up to F-1 = 1. With no item shifting, `txd`=1.
- R3: A `wr_stb` makes `buf_empty` 0 on the next cycle. The buffer empties (`buf_empty`=1) on the tick that starts its frame.
- R4: `tx_done` is 1 only when nothing is shifting and no data, idle or break item is pending.
- R5: A rising edge of `tx_en` while an item is shifting queues one idle character of F high bits. It starts on the tick that ends the current item, and it goes out before pending data.
- R6: `pin_owned` = `tx_en` OR an item is shifting. The item in progress always completes, and no new item starts while `tx_en`=0. A later rising edge of `tx_en` with nothing shifting queues nothing.
- R7: A rising edge of `brk_req` queues one break of F low bit times (10, 11 or 12), sent when the line is free.
- R8: With `brk_long`=1, the break length is F+3 (13, 14 or 15).
- R9: While `brk_req` stays high, a new break starts on the same tick that ends the previous one, leaving no high bit between them. After `brk_req` falls, the break in progress ends and no further break follows.
- R10: `txd_oe` = `pin_owned` AND (`single_wire`=0 OR `dir_out`=1).
- R11: In a cycle without `bit_tick`, `txd` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| tx_en | input | 1 | Transmit enable |
| brk_req | input | 1 | Break request (rising edge queues, high repeats) |
| brk_long | input | 1 | Selects the longer break length |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 |
| extra_stop | input | 1 | 1 = two stop bits |
| wr_stb | input | 1 | Loads `wr_data` into the buffer |
| wr_data | input | 9 | Data word; bit 8 is used only in 9-bit mode |
| single_wire | input | 1 | Shared-line mode |
| dir_out | input | 1 | In shared-line mode, 1 = drive the line |
| txd | output | 1 | Serial line value |
| txd_oe | output | 1 | Output driver enable |
| pin_owned | output | 1 | Block owns the pin |
| buf_empty | output | 1 | Data buffer empty |
| tx_done | output | 1 | Nothing shifting and nothing pending |

## Verification
The line value moves only on the clock edge that carries `bit_tick`. The bench therefore raises the tick for exactly one edge and reads `txd` at the next falling edge, so bit k of an item is due after its (k+1)-th tick. `buf_empty` and `tx_done` are due one edge after a write or a break pulse. They update again on the tick that starts or ends an item, and each check is made half a cycle after that edge. `pin_owned` and `txd_oe` follow `tx_en` and the direction inputs in the same cycle. They are read one cycle after those inputs change, and again after the tick that ends the last item.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
// Assumes: one item kind is shifted at a time; NONE means no request.
package sertx_pkg;
    typedef enum logic [1:0] {
        ITEM_NONE = 2'd0,
        ITEM_IDLE = 2'd1,
        ITEM_BRK  = 2'd2,
        ITEM_DATA = 2'd3
    } item_t;
endpackage

// File: rtl/sertx_queue.sv
// Holds the pending work: the one-entry data buffer, the idle flag and the
// break flag. Picks the next item for the shifter (idle, then break, then
// data), and offers an item only while transmit is enabled.
// Assumes: take/take_kind come from the shifter in the cycle it loads.
module sertx_queue
    import sertx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              brk_last,
    input  logic              take,
    input  item_t             take_kind,
    output item_t             nxt_kind,
    output logic [DATA_W-1:0] nxt_data,
    output logic              buf_full,
    output logic              pend_any
);
    logic              en_q;
    logic              brk_q;
    logic              idle_pend;
    logic              brk_pend;
    logic [DATA_W-1:0] buf_q;
    logic              en_rise;
    logic              brk_rise;
    logic              brk_again;
    logic              brk_want;

    assign en_rise   = tx_en & ~en_q;
    assign brk_rise  = brk_req & ~brk_q;
    // a break ending while the request is still high chains another one
    assign brk_again = bit_tick & brk_last & brk_req;
    assign brk_want  = brk_pend | brk_again;
    assign nxt_data  = buf_q;
    assign pend_any  = buf_full | idle_pend | brk_pend;

    // Purpose: keep the previous enable and break request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            en_q  <= tx_en;
            brk_q <= brk_req;
        end
    end

    // Purpose: pick the next item by fixed priority, only while enabled.
    always_comb begin
        if (!tx_en)         nxt_kind = ITEM_NONE;
        else if (idle_pend) nxt_kind = ITEM_IDLE;
        else if (brk_want)  nxt_kind = ITEM_BRK;
        else if (buf_full)  nxt_kind = ITEM_DATA;
        else                nxt_kind = ITEM_NONE;
    end

    // Purpose: the data buffer; a write wins over a same-cycle hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_q    <= '0;
        end else begin
            if (take && take_kind == ITEM_DATA) buf_full <= 1'b0;
            if (wr_stb) begin
                buf_full <= 1'b1;
                buf_q    <= wr_data;
            end
        end
    end

    // Purpose: queue an idle character on an enable rise during shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_pend <= 1'b0;
        end else begin
            if (take && take_kind == ITEM_IDLE) idle_pend <= 1'b0;
            if (en_rise && busy)                idle_pend <= 1'b1;
        end
    end

    // Purpose: queue a break on a request rise or a chained repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_pend <= 1'b0;
        end else begin
            brk_pend <= (brk_pend | brk_rise | brk_again)
                        & ~(take && take_kind == ITEM_BRK);
        end
    end
endmodule

// File: rtl/sertx_shift.sv
// Shifts one item onto the line, one bit per tick, LSB first. The frame
// length and the fill bit are fixed when the item loads. On the tick that
// ends an item, the next item may load at once, so back-to-back items
// leave no gap.
// Assumes: nxt_kind is NONE whenever nothing may start.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W     = 9,
    parameter int LONG_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  item_t             nxt_kind,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic              nine_bit,
    input  logic              extra_stop,
    input  logic              brk_long,
    output logic              busy,
    output logic              brk_last,
    output logic              take,
    output item_t             take_kind,
    output logic              line
);
    localparam int SHIFT_W = DATA_W + 3 + LONG_EXTRA;
    localparam int CNT_W   = $clog2(SHIFT_W + 1);
    localparam int BASE    = DATA_W + 1;

    item_t              cur_kind;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   len;
    logic [SHIFT_W-1:0] sh;
    logic               fill;
    logic               last;
    logic [CNT_W-1:0]   frame_len;
    logic [SHIFT_W-1:0] ld_vec;
    logic [CNT_W-1:0]   ld_len;
    logic               ld_fill;

    assign last      = busy && (cnt == len - CNT_W'(1));
    assign brk_last  = last && (cur_kind == ITEM_BRK);
    assign take      = bit_tick && (!busy || last) && (nxt_kind != ITEM_NONE);
    assign take_kind = nxt_kind;
    assign line      = busy ? sh[0] : 1'b1;
    assign frame_len = CNT_W'(BASE) + CNT_W'(nine_bit) + CNT_W'(extra_stop);

    // Purpose: build the bit pattern, length and fill bit of the next item.
    always_comb begin
        ld_vec  = '1;
        ld_len  = frame_len;
        ld_fill = 1'b1;
        case (nxt_kind)
            ITEM_DATA: begin
                ld_vec[0] = 1'b0;
                if (nine_bit) ld_vec[DATA_W:1]   = nxt_data;
                else          ld_vec[DATA_W-1:1] = nxt_data[DATA_W-2:0];
            end
            ITEM_BRK: begin
                ld_vec  = '0;
                ld_fill = 1'b0;
                ld_len  = frame_len + (brk_long ? CNT_W'(LONG_EXTRA) : CNT_W'(0));
            end
            default: begin
                ld_vec = '1;
            end
        endcase
    end

    // Purpose: load, advance or retire the item in the shifter on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_kind <= ITEM_NONE;
            cnt      <= '0;
            len      <= '0;
            sh       <= '1;
            fill     <= 1'b1;
        end else if (bit_tick) begin
            if (take) begin
                busy     <= 1'b1;
                cur_kind <= nxt_kind;
                cnt      <= '0;
                len      <= ld_len;
                sh       <= ld_vec;
                fill     <= ld_fill;
            end else if (last) begin
                busy     <= 1'b0;
                cur_kind <= ITEM_NONE;
                sh       <= '1;
            end else if (busy) begin
                cnt <= cnt + CNT_W'(1);
                sh  <= {fill, sh[SHIFT_W-1:1]};
            end
        end
    end
endmodule

// File: rtl/sertx_pin.sv
// Pin control: ownership follows the enable, and is kept while an item is
// still shifting. In shared-line mode the driver also needs the direction
// input set to drive.
// Assumes: line is already high whenever nothing is shifting.
module sertx_pin (
    input  logic tx_en,
    input  logic busy,
    input  logic line,
    input  logic single_wire,
    input  logic dir_out,
    output logic txd,
    output logic txd_oe,
    output logic pin_owned
);
    // Purpose: derive ownership, driver enable and line value.
    always_comb begin
        pin_owned = tx_en | busy;
        txd_oe    = pin_owned & (~single_wire | dir_out);
        txd       = line;
    end
endmodule

// File: rtl/sertx_core.sv
// Top of the serial transmitter: the pending-work queue, the bit shifter
// and the pin control, tied together.
// Assumes: bit_tick is a one-cycle strobe at the bit rate from outside.
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DATA_W     = 9,
    parameter int LONG_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              brk_long,
    input  logic              nine_bit,
    input  logic              extra_stop,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              single_wire,
    input  logic              dir_out,
    output logic              txd,
    output logic              txd_oe,
    output logic              pin_owned,
    output logic              buf_empty,
    output logic              tx_done
);
    item_t             nxt_kind;
    item_t             take_kind;
    logic [DATA_W-1:0] nxt_data;
    logic              buf_full;
    logic              pend_any;
    logic              busy;
    logic              brk_last;
    logic              take;
    logic              line;

    sertx_queue #(.DATA_W(DATA_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .brk_req(brk_req), .wr_stb(wr_stb), .wr_data(wr_data), .busy(busy),
        .brk_last(brk_last), .take(take), .take_kind(take_kind),
        .nxt_kind(nxt_kind), .nxt_data(nxt_data), .buf_full(buf_full),
        .pend_any(pend_any)
    );

    sertx_shift #(.DATA_W(DATA_W), .LONG_EXTRA(LONG_EXTRA)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .nxt_kind(nxt_kind),
        .nxt_data(nxt_data), .nine_bit(nine_bit), .extra_stop(extra_stop),
        .brk_long(brk_long), .busy(busy), .brk_last(brk_last), .take(take),
        .take_kind(take_kind), .line(line)
    );

    sertx_pin u_pin (
        .tx_en(tx_en), .busy(busy), .line(line), .single_wire(single_wire),
        .dir_out(dir_out), .txd(txd), .txd_oe(txd_oe), .pin_owned(pin_owned)
    );

    // Purpose: status flags seen at the ports.
    always_comb begin
        buf_empty = ~buf_full;
        tx_done   = ~busy & ~pend_any;
    end
endmodule

// File: rtl/sertx_core_chk.sv
// Port-level properties of the serial transmitter, bound to the top.
module sertx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_en,
    input logic wr_stb,
    input logic single_wire,
    input logic dir_out,
    input logic txd,
    input logic txd_oe,
    input logic pin_owned,
    input logic buf_empty,
    input logic tx_done
);
    AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (buf_empty && tx_done && txd)); // R1
    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !bit_tick |=> $stable(txd)); // R11
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !buf_empty); // R3
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> buf_empty); // R4
    AST_EN_OWNS: assert property (@(posedge clk) disable iff (!rst_n) tx_en |-> pin_owned); // R6
    AST_FREE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !pin_owned |-> txd); // R2
    AST_OE_OWNED: assert property (@(posedge clk) disable iff (!rst_n) txd_oe |-> pin_owned); // R10
    AST_OE_DIR: assert property (@(posedge clk) disable iff (!rst_n) (single_wire && !dir_out) |-> !txd_oe); // R10
endmodule

bind sertx_core sertx_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .wr_stb(wr_stb), .single_wire(single_wire), .dir_out(dir_out),
    .txd(txd), .txd_oe(txd_oe), .pin_owned(pin_owned),
    .buf_empty(buf_empty), .tx_done(tx_done)
);

// File: tb/sertx_core_bench.sv
module sertx_core_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       brk_long = 1'b0;
    logic       nine_bit = 1'b0;
    logic       extra_stop = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       single_wire = 1'b0;
    logic       dir_out = 1'b0;
    logic       txd, txd_oe, pin_owned, buf_empty, tx_done;
    int         n_checks = 0;
    int         n_fail = 0;

    sertx_core u_sertx_core (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .brk_req(brk_req), .brk_long(brk_long), .nine_bit(nine_bit),
        .extra_stop(extra_stop), .wr_stb(wr_stb), .wr_data(wr_data),
        .single_wire(single_wire), .dir_out(dir_out), .txd(txd),
        .txd_oe(txd_oe), .pin_owned(pin_owned), .buf_empty(buf_empty),
        .tx_done(tx_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int frame_len(logic nb, logic es);
        return 10 + int'(nb) + int'(es);
    endfunction

    function automatic int break_len(logic nb, logic es, logic lg);
        return frame_len(nb, es) + (lg ? 3 : 0);
    endfunction

    function automatic logic frame_bit(logic [8:0] d, logic nb, int i);
        int nbits = nb ? 9 : 8;
        if (i == 0) return 1'b0;
        if (i <= nbits) return d[i-1];
        return 1'b1;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic write(logic [8:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    // Shift out one data frame and compare every bit; started=1 means its
    // start tick has already happened.
    task automatic check_frame(string req, logic [8:0] d, bit started, int gap);
        int f = frame_len(nine_bit, extra_stop);
        int bad = 0;
        for (int i = 0; i < f; i++) begin
            if (!(i == 0 && started)) tick();
            if (txd !== frame_bit(d, nine_bit, i)) bad++;
            for (int g = 0; g < gap; g++) cyc();
        end
        check(req, "frame bits wrong", bad, 0);
    endtask

    // Count the low bit times of a break that starts on the next tick.
    task automatic count_low(output int n);
        n = 0;
        tick();
        while (txd == 1'b0 && n < 40) begin
            n++;
            tick();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int n;
        logic [8:0] d;
        logic [8:0] d2;
        int f;
        void'($urandom(32'h5eed_1234));

        // R1: reset state
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        check("R1", "buf_empty", buf_empty, 1);
        check("R1", "tx_done", tx_done, 1);
        check("R1", "txd idle", txd, 1);
        check("R1", "pin_owned", pin_owned, 0);

        // R11: a held start bit without ticks
        tx_en = 1'b1;
        cyc();
        write(9'h0A5);
        check("R3", "buf_empty after write", buf_empty, 0);
        check("R4", "tx_done after write", tx_done, 0);
        tick();
        check("R3", "buf_empty after start", buf_empty, 1);
        repeat (5) cyc();
        check("R11", "start bit held without tick", txd, 0);
        check_frame("R2", 9'h0A5, 1'b1, 0);
        tick();
        check("R4", "tx_done after frame", tx_done, 1);

        // R2: random frames, formats and tick spacing
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            nine_bit   = 1'($urandom);
            extra_stop = 1'($urandom);
            d = 9'($urandom);
            write(d);
            check_frame("R2", d, 1'b0, int'($urandom % 3));
            tick();
            check("R4", "done after random frame", tx_done, 1);
        end
        @(negedge clk);
        nine_bit = 1'b0;
        extra_stop = 1'b0;

        // R5: enable toggled mid-frame queues idle ahead of data
        d = 9'h03C;
        d2 = 9'h1C3;
        f = frame_len(nine_bit, extra_stop);
        write(d);
        tick();
        @(negedge clk);
        tx_en = 1'b0;
        cyc();
        check("R6", "owned while disabled mid-frame", pin_owned, 1);
        tx_en = 1'b1;
        cyc();
        write(d2);
        repeat (f - 1) tick();
        repeat (f) tick();
        check("R5", "idle line high", txd, 1);
        check("R5", "tx_done during idle", tx_done, 0);
        tick();
        check("R5", "data start after idle", txd, 0);
        check_frame("R5", d2, 1'b1, 0);
        tick();
        check("R5", "done after idle+data", tx_done, 1);

        // R6: release after disable, nothing starts while disabled
        d = 9'h155;
        write(d);
        tick();
        @(negedge clk);
        tx_en = 1'b0;
        n = 0;
        for (int i = 1; i < f; i++) begin
            tick();
            if (pin_owned !== 1'b1) n++;
        end
        check("R6", "ownership lost early", n, 0);
        d2 = 9'h0F0;
        write(d2);
        tick();
        check("R6", "pin_owned after finish", pin_owned, 0);
        check("R10", "txd_oe after release", txd_oe, 0);
        check("R4", "tx_done with pending data", tx_done, 0);
        tick();
        check("R6", "no start while disabled", txd, 1);
        @(negedge clk);
        tx_en = 1'b1;
        cyc();
        check_frame("R6", d2, 1'b0, 0);
        tick();
        check("R6", "done after re-enable", tx_done, 1);

        // R7: single break, short
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        cyc();
        check("R4", "tx_done with break pending", tx_done, 0);
        count_low(n);
        check("R7", "break length 8-bit", n, break_len(1'b0, 1'b0, 1'b0));
        check("R7", "done after break", tx_done, 1);

        // R8: long break at the longest frame
        @(negedge clk);
        nine_bit = 1'b1;
        extra_stop = 1'b1;
        brk_long = 1'b1;
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        count_low(n);
        check("R8", "long break length", n, break_len(1'b1, 1'b1, 1'b1));

        // R7: short break, 9-bit
        @(negedge clk);
        extra_stop = 1'b0;
        brk_long = 1'b0;
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        count_low(n);
        check("R7", "break length 9-bit", n, break_len(1'b1, 1'b0, 1'b0));

        // R9: held request chains breaks without a gap
        @(negedge clk);
        nine_bit = 1'b0;
        brk_req = 1'b1;
        f = break_len(1'b0, 1'b0, 1'b0);
        n = 0;
        for (int i = 0; i < 2 * f; i++) begin
            tick();
            if (txd !== 1'b0) n++;
        end
        check("R9", "gap in held break", n, 0);
        @(negedge clk);
        brk_req = 1'b0;
        tick();
        check("R9", "line high after release", txd, 1);
        check("R9", "done after held break", tx_done, 1);

        // R10: direction control in shared-line mode
        @(negedge clk);
        single_wire = 1'b1;
        dir_out = 1'b0;
        cyc();
        check("R10", "oe off when receiving", txd_oe, 0);
        check("R6", "still owned", pin_owned, 1);
        dir_out = 1'b1;
        cyc();
        check("R10", "oe on when driving", txd_oe, 1);
        single_wire = 1'b0;
        dir_out = 1'b0;
        cyc();
        check("R10", "oe on in two-wire", txd_oe, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule